// File: doc/BRIEF.md
# Fourth-Order CIC Decimator by 32 with Three-Tap Droop Compensator

This block is the first rate-reduction stage behind a single-bit noise-shaping modulator. Every accepted input bit is mapped to +1 or -1 and fed into four cascaded integrators. A sample counter picks one integrator result out of every 32 valid input samples. That result then passes once through four comb (first-difference) stages. A symmetric three-tap FIR with coefficients -1, 10, -1 follows the combs. It lifts the band edge to offset the sinc roll-off of the CIC before any later half-band stages.

All arithmetic is two's complement and wraps at its register width. The integrators and combs are 22 bits wide: the 2-bit input plus 4 x 5 growth bits. The compensator output has 4 more guard bits, giving 26 bits. The compensator products use only shifts and additions. The coefficient 10 is built as 8 + 2. The coefficient -1 is a negation of the folded sum of the two outer taps.

A three-state sequencer controls the low-rate part:
- GATHER waits for the 32nd valid sample.
- GATHER -> COMB on the edge that accepts the 32nd valid sample.
- COMB -> FIR after one cycle, during which the combs update.
- FIR -> GATHER after one cycle, during which the compensator updates and the output word is registered.

Top module: `cicd_decimator`

## Requirements
- R1: An input bit of 1 enters the integrators as +1, and an input bit of 0 enters as -1.
- R2: On each valid sample, integrator 0 adds the mapped input, and integrator k (k = 1..3) adds the value integrator k-1 held before that sample. All integrators are 22-bit registers that wrap modulo 2^22.
- R3: Exactly one decimated value is taken per 32 samples with in_valid high. The value taken is integrator 3 including the 32nd sample. Cycles with in_valid low change no state, whatever in_bit is.
- R4: Each of the four comb stages outputs its input minus the input it received at the previous decimated instant, with 22-bit wrap.
- R5: With c[m] the comb output at decimated instant m, the output word is y[m] = -c[m] + 10*c[m-1] - c[m-2], as a 26-bit signed value.
- R6: out_valid is a one-cycle pulse. It is high in the cycle after the second rising edge that follows the edge accepting the 32nd valid sample. out_data changes only at the edge that raises out_valid.
- R7: A constant input settles to out_data = +8388608 for all ones and to -8388608 for all zeros. This is 8 * 32^4.
- R8: A synchronous reset clears the integrators, sample counter, comb delays, compensator taps, out_valid and out_data. It returns the sequencer to GATHER, so counting of 32 samples restarts from zero.
- R9: The sequencer steps GATHER -> COMB -> FIR -> GATHER, spending exactly one cycle each in COMB and in FIR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the input sample rate or faster |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_bit for this cycle |
| in_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| out_valid | output | 1 | One-cycle pulse marking a new decimated word |
| out_data | output | 26 | Compensated decimated sample, signed |

## Verification
Each output word is due in the cycle after the second rising edge that follows the edge accepting the 32nd valid sample. The bench records that edge when it feeds the sample and computes the expected word from the recursions of R2, R4 and R5. It samples out_valid and out_data on the falling edge three falling edges later. A pulse on any other falling edge counts as a failure, and so does a missing pulse on the due one. This one rule covers R6 and R9 under continuous input, gapped input and input applied right after a reset.

// File: rtl/cicd_pkg.sv
package cicd_pkg;

    localparam int CIC_ORDER     = 4;
    localparam int DEC_RATE_LOG2 = 5;
    localparam int SAMPLE_W      = 2;
    localparam int FIR_GUARD_W   = 4;

    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_COMB   = 2'd1,
        ST_FIR    = 2'd2
    } seq_state_t;

endpackage

// File: rtl/cicd_integrators.sv
module cicd_integrators #(
    parameter int ORDER = 4,
    parameter int ACC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    in_bit,
    output logic signed [ACC_W-1:0] last_next
);

    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] acc_d [ORDER];
    logic signed [ACC_W-1:0] step;

    // 1 -> +1, 0 -> -1 (R1)
    assign step = {{(ACC_W-1){~in_bit}}, 1'b1};

    always_comb begin
        acc_d[0] = acc_q[0] + step;
        for (int k = 1; k < ORDER; k++) begin
            acc_d[k] = acc_q[k] + acc_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ORDER; k++) acc_q[k] <= '0;
        end else if (en) begin
            for (int k = 0; k < ORDER; k++) acc_q[k] <= acc_d[k];
        end
    end

    assign last_next = acc_d[ORDER-1];

    AST_INTEG_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q[ORDER-1])); // R3

    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !$past(rst)) |=> (acc_q[0] - $past(acc_q[0]) == ($past(in_bit) ? ACC_W'(1) : -ACC_W'(1)))); // R1

endmodule

// File: rtl/cicd_combs.sv
module cicd_combs #(
    parameter int ORDER = 4,
    parameter int ACC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);

    logic signed [ACC_W-1:0] chain [ORDER+1];

    assign chain[0] = din;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic signed [ACC_W-1:0] dly_q;

        assign chain[g+1] = chain[g] - dly_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q <= '0;
            end else if (en) begin
                dly_q <= chain[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (en) begin
            dout <= chain[ORDER];
        end
    end

    AST_COMB_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout)); // R4

endmodule

// File: rtl/cicd_droop_fir.sv
module cicd_droop_fir #(
    parameter int IN_W      = 22,
    parameter int OUT_W     = 26,
    parameter int OUTER_SH  = 0,
    parameter int CENTER_HI = 3,
    parameter int CENTER_LO = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);

    localparam int EXT_W = OUT_W - IN_W;

    logic signed [IN_W-1:0]  tap_near_q;
    logic signed [IN_W-1:0]  tap_far_q;
    logic signed [OUT_W-1:0] new_x;
    logic signed [OUT_W-1:0] near_x;
    logic signed [OUT_W-1:0] far_x;
    logic signed [OUT_W-1:0] folded;
    logic signed [OUT_W-1:0] outer_prod;
    logic signed [OUT_W-1:0] center_prod;
    logic signed [OUT_W-1:0] sum;

    assign new_x  = {{EXT_W{din[IN_W-1]}}, din};
    assign near_x = {{EXT_W{tap_near_q[IN_W-1]}}, tap_near_q};
    assign far_x  = {{EXT_W{tap_far_q[IN_W-1]}}, tap_far_q};

    // outer taps share one product through folding; coefficient -2^OUTER_SH
    assign folded      = new_x + far_x;
    assign outer_prod  = -(folded <<< OUTER_SH);
    // center coefficient 2^HI + 2^LO as two shifted copies
    assign center_prod = (near_x <<< CENTER_HI) + (near_x <<< CENTER_LO);
    assign sum         = outer_prod + center_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_near_q <= '0;
            tap_far_q  <= '0;
            dout       <= '0;
        end else if (en) begin
            tap_near_q <= din;
            tap_far_q  <= tap_near_q;
            dout       <= sum;
        end
    end

    AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        en |=> (tap_far_q == $past(tap_near_q))); // R5

endmodule

// File: rtl/cicd_decimator.sv
module cicd_decimator
    import cicd_pkg::*;
#(
    parameter int ORDER     = CIC_ORDER,
    parameter int RATE_LOG2 = DEC_RATE_LOG2,
    parameter int IN_W      = SAMPLE_W,
    parameter int GUARD_W   = FIR_GUARD_W,
    localparam int ACC_W    = IN_W + ORDER * RATE_LOG2,
    localparam int OUT_W    = ACC_W + GUARD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_bit,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    seq_state_t state_q;
    seq_state_t state_d;

    logic [RATE_LOG2-1:0]    phase_q;
    logic                    take_now;
    logic signed [ACC_W-1:0] integ_next;
    logic signed [ACC_W-1:0] dec_q;
    logic signed [ACC_W-1:0] comb_out;

    assign take_now = in_valid && (phase_q == '1);

    cicd_integrators #(
        .ORDER (ORDER),
        .ACC_W (ACC_W)
    ) integ_i (
        .clk       (clk),
        .rst       (rst),
        .en        (in_valid),
        .in_bit    (in_bit),
        .last_next (integ_next)
    );

    cicd_combs #(
        .ORDER (ORDER),
        .ACC_W (ACC_W)
    ) comb_i (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q == ST_COMB),
        .din  (dec_q),
        .dout (comb_out)
    );

    cicd_droop_fir #(
        .IN_W      (ACC_W),
        .OUT_W     (OUT_W),
        .OUTER_SH  (0),
        .CENTER_HI (3),
        .CENTER_LO (1)
    ) fir_i (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q == ST_FIR),
        .din  (comb_out),
        .dout (out_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GATHER;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER: if (take_now) state_d = ST_COMB;
            ST_COMB:   state_d = ST_FIR;
            ST_FIR:    state_d = ST_GATHER;
            default:   state_d = ST_GATHER;
        endcase
    end

    // outputs and rate counter
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= '0;
            dec_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            if (in_valid) phase_q <= phase_q + 1'b1;
            if (take_now) dec_q <= integ_next;
            out_valid <= (state_q == ST_FIR);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R6

    AST_FIR_RAISES_VALID: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIR) |=> out_valid); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_data)); // R6

    AST_COMB_TO_FIR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMB) |=> (state_q == ST_FIR)); // R9

    AST_FIR_TO_GATHER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIR) |=> (state_q == ST_GATHER)); // R9

    AST_TAKE_STARTS_COMB: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GATHER && in_valid && phase_q == '1) |=> (state_q == ST_COMB)); // R3

endmodule

// File: tb/cicd_decimator_tb_top.sv
module cicd_decimator_tb_top;

    localparam int ACC_W = 22;
    localparam int OUT_W = 26;
    localparam int RATE  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_pulses = 0;
    int exp_due = -1;
    logic signed [OUT_W-1:0] exp_val = '0;
    string cur_req = "R5";
    logic [15:0] lfsr = 16'hACE1;

    logic signed [ACC_W-1:0] m_acc [4];
    logic signed [ACC_W-1:0] m_dly [4];
    logic signed [ACC_W-1:0] m_t0, m_t1;
    int m_cnt;

    cicd_decimator dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // falling-edge monitor: output words must appear exactly when due
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (out_valid) n_pulses++;
        if (cyc == exp_due) begin
            check(out_valid === 1'b1, {cur_req, " out_valid at due cycle"}, longint'(out_valid), 1);
            check(out_data === exp_val, {cur_req, " out_data"}, longint'(out_data), longint'(exp_val));
            exp_due = -1;
        end else if (out_valid !== 1'b0 && !rst) begin
            check(1'b0, {cur_req, " unexpected out_valid"}, longint'(out_valid), 0);
        end
    end

    function automatic void model_reset();
        for (int k = 0; k < 4; k++) begin
            m_acc[k] = '0;
            m_dly[k] = '0;
        end
        m_t0 = '0;
        m_t1 = '0;
        m_cnt = 0;
    endfunction

    function automatic void model_step(input logic b);
        logic signed [ACC_W-1:0] x, c, t;
        longint y;
        x = b ? ACC_W'(1) : -ACC_W'(1);
        for (int k = 3; k >= 1; k--) m_acc[k] = m_acc[k] + m_acc[k-1];
        m_acc[0] = m_acc[0] + x;
        m_cnt++;
        if (m_cnt == RATE) begin
            m_cnt = 0;
            c = m_acc[3];
            for (int k = 0; k < 4; k++) begin
                t = c - m_dly[k];
                m_dly[k] = c;
                c = t;
            end
            y = 10 * longint'(m_t0) - longint'(c) - longint'(m_t1);
            m_t1 = m_t0;
            m_t0 = c;
            exp_val = OUT_W'(y);
            exp_due = cyc + 3;
        end
    endfunction

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic feed(input logic b, input logic v);
        @(negedge clk);
        in_bit = b;
        in_valid = v;
        @(posedge clk);
        #1;
        if (v) model_step(b);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) feed(next_rand(), 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        exp_due = -1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R8: outputs cleared by reset
    task automatic t_reset_state();
        do_reset();
        #1;
        check(out_valid === 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
        check(out_data === '0, "R8 out_data after reset", longint'(out_data), 0);
    endtask

    // R7 / R1: constant input level
    task automatic t_const(input logic lvl, input int nout, input string req);
        int p0;
        do_reset();
        cur_req = req;
        p0 = n_pulses;
        for (int i = 0; i < nout * RATE; i++) feed(lvl, 1'b1);
        settle(4);
        check(out_data === (lvl ? OUT_W'(8388608) : -OUT_W'(8388608)),
              {req, " steady level"}, longint'(out_data), lvl ? 8388608 : -8388608);
        check(n_pulses - p0 == nout, "R3 pulse count", n_pulses - p0, nout);
    endtask

    // R4: alternating input settles to zero
    task automatic t_alternate();
        do_reset();
        cur_req = "R4";
        for (int i = 0; i < 10 * RATE; i++) feed(logic'(i[0]), 1'b1);
        settle(4);
        check(out_data === '0, "R4 alternating steady", longint'(out_data), 0);
    endtask

    // R2 / R5: long pseudo-random stream
    task automatic t_random();
        do_reset();
        cur_req = "R5";
        for (int i = 0; i < 24 * RATE; i++) feed(next_rand(), 1'b1);
        cur_req = "R2";
        for (int i = 0; i < 40 * RATE; i++) feed(1'b1, 1'b1);
        for (int i = 0; i < 8 * RATE; i++) feed(next_rand(), 1'b1);
        settle(4);
    endtask

    // R3: cycles with in_valid low are ignored
    task automatic t_gaps();
        int p0;
        do_reset();
        cur_req = "R3";
        p0 = n_pulses;
        for (int i = 0; i < 6 * RATE; i++) begin
            feed(next_rand(), 1'b1);
            feed(next_rand(), 1'b0);
            if (i % 7 == 3) feed(next_rand(), 1'b0);
        end
        settle(4);
        check(n_pulses - p0 == 6, "R3 gapped pulse count", n_pulses - p0, 6);
    endtask

    // R9 / R6: exact timing around the 32nd sample
    task automatic t_timing();
        do_reset();
        cur_req = "R9";
        for (int i = 0; i < RATE - 1; i++) feed(1'b1, 1'b1);
        feed(1'b0, 1'b0);
        feed(1'b0, 1'b0);
        #1;
        check(out_valid === 1'b0, "R9 no output before 32nd sample", longint'(out_valid), 0);
        feed(1'b1, 1'b1);
        cur_req = "R6";
        settle(5);
        check(n_pulses >= 1, "R6 pulse seen", n_pulses, 1);
    endtask

    // R8: reset mid-frame restarts the count
    task automatic t_midreset();
        int p0;
        do_reset();
        cur_req = "R8";
        for (int i = 0; i < 20; i++) feed(next_rand(), 1'b1);
        do_reset();
        #1;
        check(out_data === '0, "R8 out_data after mid reset", longint'(out_data), 0);
        p0 = n_pulses;
        for (int i = 0; i < 8 * RATE - 1; i++) feed(1'b1, 1'b1);
        settle(4);
        check(n_pulses - p0 == 7, "R8 count restarted", n_pulses - p0, 7);
        feed(1'b1, 1'b1);
        settle(4);
        check(out_data === OUT_W'(8388608), "R8 level after restart", longint'(out_data), 8388608);
    endtask

    initial begin
        model_reset();
        t_reset_state();
        t_const(1'b1, 10, "R7");
        t_const(1'b0, 10, "R1");
        t_alternate();
        t_random();
        t_gaps();
        t_timing();
        t_midreset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule